// File: doc/BRIEF.md
# Motion Sensor Control and Interrupt Register Bank

This block is the register-mapped front end of a three-axis motion sensor. A byte-wide register port reaches it, for example one sitting behind a serial target controller. It holds the main control byte, which sets power state, resolution, range and the enables for the motion functions. It also gathers event strobes from the data path and from the motion detectors into latched source bits. From those bits it drives a level interrupt pin and a status flag.

Configuration that the data path depends on (resolution, data-ready enable, range) is frozen while the sensor is operating. It can only change from standby. A write that brings the sensor out of standby may still load it.

Software services an interrupt in two steps. It reads the source registers. It then reads the release address, which clears every latched source, the status flag and the pin in one access.

Top module: `motion_regbank`

## Requirements
- R1: After reset the control byte (address 0x1B) reads 0x00, both source registers and the status register read 0x00, and `irq_o` is low.
- R2: In standby (control bit 7 = 0), a write to 0x1B stores all eight bits and a read of 0x1B returns them. Control layout: bit 7 power (1 = operating), bit 6 resolution (1 = 12-bit high current, 0 = 8-bit low current), bit 5 data-ready enable, bits 4:3 range select, bit 2 tap enable, bit 1 wake-up enable, bit 0 tilt enable.
- R3: While operating, a write to 0x1B leaves bits 6:3 unchanged and stores bits 7, 2, 1 and 0 from the written value.
- R4: A write issued while in standby that sets bit 7 also stores the written bits 6:3 in that same write.
- R5: While operating, a `ev_drdy_i` pulse sets source register A (0x15) bit 0 only when control bit 5 is 1.
- R6: While operating, `ev_tap_i`, `ev_wake_i` and `ev_tilt_i` pulses set source register B (0x16) bits 2, 1 and 0, each only when its enable bit (2, 1, 0) is 1.
- R7: `irq_o` and status register (0x18) bit 4 are high exactly while any source bit is latched, and they stay high with no further events until the release read.
- R8: A read of 0x1A returns 0x00 and clears both source registers, the status bit and `irq_o` on that clock edge.
- R9: An enabled event that arrives in the same cycle as the release read stays latched after that read.
- R10: While in standby, event inputs have no effect on any source bit or on `irq_o`.
- R11: Reads of any address other than 0x15, 0x16, 0x18 and 0x1B return 0x00 and clear nothing. Writes to any address other than 0x1B change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| rd_en_i | input | 1 | Register read strobe, one cycle per read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| ev_drdy_i | input | 1 | New acceleration data strobe |
| ev_tap_i | input | 1 | Tap detection event strobe |
| ev_wake_i | input | 1 | Wake-up detection event strobe |
| ev_tilt_i | input | 1 | Tilt detection event strobe |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
The hardest situation to reach from the ports is a release read that lands in the same clock cycle as a fresh enabled event. The bench drives the release strobe and a tap pulse on the same falling edge, so both are seen at one rising edge. It then checks that the tap bit and the pin survive. Gated writes are swept over all 256 data values, each starting from a base whose frozen bits are the complement of the written ones, so every write tries to flip all of them. All 256 combinations of the four enables and four event lines are also swept.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int DW       = 8;
  localparam int AW       = 8;
  localparam int NSRC     = 4;
  // register addresses
  localparam logic [AW-1:0] A_SRC_A  = 8'h15;
  localparam logic [AW-1:0] A_SRC_B  = 8'h16;
  localparam logic [AW-1:0] A_STATUS = 8'h18;
  localparam logic [AW-1:0] A_REL    = 8'h1A;
  localparam logic [AW-1:0] A_CTRL   = 8'h1B;
  // control bit positions
  localparam int B_PWR   = 7;
  localparam int B_RES   = 6;
  localparam int B_DRDYE = 5;
  localparam int B_TAPE  = 2;
  localparam int B_WAKEE = 1;
  localparam int B_TILTE = 0;
  localparam int B_STAT_IRQ = 4;
  // bits frozen while operating
  localparam logic [DW-1:0] FROZEN_MASK = 8'h78;
  // source vector index order
  localparam int S_TILT = 0;
  localparam int S_WAKE = 1;
  localparam int S_TAP  = 2;
  localparam int S_DRDY = 3;
endpackage

// File: rtl/mrb_ctrl_reg.sv
module mrb_ctrl_reg
  import mrb_pkg::*;
#(
  parameter int W = DW,
  parameter logic [W-1:0] MASK = FROZEN_MASK,
  parameter int PWR_BIT = B_PWR
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o
);
  logic [W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_q[PWR_BIT]) ctrl_d = (ctrl_q & MASK) | (wdata_i & ~MASK);
    else                 ctrl_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R3: frozen bits hold across a write made while operating
  a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && ctrl_q[PWR_BIT]) |=> ((ctrl_q & MASK) == ($past(ctrl_q) & MASK)));
  // R2 / R4: a standby write stores the whole byte, power-up included
  a_r4_standby_load: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && !ctrl_q[PWR_BIT]) |=> (ctrl_q == $past(wdata_i)));
  // R11: no write strobe, no change
  a_r11_no_wr_stable: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/mrb_irq_latch.sv
module mrb_irq_latch
  import mrb_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         pwr_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] ev_i,
  input  logic         rel_i,
  output logic [N-1:0] src_o,
  output logic         irq_o
);
  logic [N-1:0] src_q;
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic nxt;
    assign hit[i] = pwr_i & en_i[i] & ev_i[i];
    always_comb begin
      nxt = src_q[i];
      if (rel_i) nxt = 1'b0;
      if (hit[i]) nxt = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)                    src_q[i] <= 1'b0;
      else if (rel_i || hit[i])       src_q[i] <= nxt;
    end
  end

  assign src_o = src_q;
  assign irq_o = |src_q;

  // R8: release with no new event empties every source
  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (rel_i && !(|(ev_i & en_i))) |=> (src_o == '0));
  // R9: an enabled event during operation is never lost, release or not
  a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_ni)
    (pwr_i && |(ev_i & en_i)) |=> (src_o != '0));
  // R10: standby events change nothing except via release
  a_r10_standby_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (!pwr_i && !rel_i) |=> $stable(src_o));
  // R7: interrupt holds until release
  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_o && !rel_i) |=> irq_o);
endmodule

// File: rtl/mrb_read_mux.sv
module mrb_read_mux
  import mrb_pkg::*;
(
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   ctrl_i,
  input  logic [NSRC-1:0] src_i,
  input  logic            irq_i,
  output logic [DW-1:0]   rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SRC_A:  rdata_o[0] = src_i[S_DRDY];
      A_SRC_B:  rdata_o[2:0] = {src_i[S_TAP], src_i[S_WAKE], src_i[S_TILT]};
      A_STATUS: rdata_o[B_STAT_IRQ] = irq_i;
      A_CTRL:   rdata_o = ctrl_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/motion_regbank.sv
module motion_regbank
  import mrb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ev_drdy_i,
  input  logic          ev_tap_i,
  input  logic          ev_wake_i,
  input  logic          ev_tilt_i,
  output logic          irq_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [DW-1:0]   ctrl;
  logic [NSRC-1:0] src, en, ev;
  logic            ctrl_wr, rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
  assign rel     = rd_en_i && (addr_i == A_REL);

  assign en[S_TILT] = ctrl[B_TILTE];
  assign en[S_WAKE] = ctrl[B_WAKEE];
  assign en[S_TAP]  = ctrl[B_TAPE];
  assign en[S_DRDY] = ctrl[B_DRDYE];
  assign ev = {ev_drdy_i, ev_tap_i, ev_wake_i, ev_tilt_i};

  mrb_ctrl_reg #(.W(DW), .MASK(FROZEN_MASK), .PWR_BIT(B_PWR)) u_ctrl (
    .clk(clk), .rst_ni(rst_int_n), .wr_i(ctrl_wr),
    .wdata_i(wdata_i), .ctrl_o(ctrl));

  mrb_irq_latch #(.N(NSRC)) u_irq (
    .clk(clk), .rst_ni(rst_int_n), .pwr_i(ctrl[B_PWR]), .en_i(en),
    .ev_i(ev), .rel_i(rel), .src_o(src), .irq_o(irq_o));

  mrb_read_mux u_mux (
    .addr_i(addr_i), .ctrl_i(ctrl), .src_i(src), .irq_i(irq_o),
    .rdata_o(rdata_o));

  // R1: held in reset means quiet pin and cleared control
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |=> (!irq_o && ctrl == '0));
endmodule

// File: tb/motion_regbank_test.sv
module motion_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       ev_drdy = 0, ev_tap = 0, ev_wake = 0, ev_tilt = 0;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  motion_regbank uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ev_drdy_i(ev_drdy), .ev_tap_i(ev_tap), .ev_wake_i(ev_wake),
    .ev_tilt_i(ev_tilt), .irq_o(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(logic [3:0] e); // {drdy,tap,wake,tilt}
    @(negedge clk); {ev_drdy, ev_tap, ev_wake, ev_tilt} = e;
    @(negedge clk); {ev_drdy, ev_tap, ev_wake, ev_tilt} = 4'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h1B, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h15, v); chk("R1 srcA", v, 8'h00);
    rd(8'h16, v); chk("R1 srcB", v, 8'h00);
    rd(8'h18, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 standby writes, all values with power clear
    for (int w = 0; w < 128; w++) begin
      wr(8'h1B, w[7:0]); rd(8'h1B, v); chk("R2 standby rw", v, w[7:0]);
    end

    // R3/R4 gated writes while operating, all data values
    for (int w = 0; w < 256; w++) begin
      logic [7:0] base, exp;
      base = 8'h80 | (~w[7:0] & 8'h78);
      wr(8'h1B, 8'h00);
      wr(8'h1B, base);
      rd(8'h1B, v); chk("R4 power-up load", v, base);
      wr(8'h1B, w[7:0]);
      exp = (base & 8'h78) | (w[7:0] & 8'h87);
      rd(8'h1B, v); chk("R3 frozen bits", v, exp);
    end

    // R5/R6/R7/R8 enables x events sweep
    for (int en = 0; en < 16; en++) begin
      for (int e = 0; e < 16; e++) begin
        logic [3:0] lat;
        wr(8'h1B, 8'h00);
        wr(8'h1B, {1'b1, 1'b0, en[3], 2'b00, en[2:0]});
        rd(8'h1A, v);
        pulse(e[3:0]);
        lat = e[3:0] & en[3:0];
        rd(8'h15, v); chk("R5 srcA drdy", v, {7'b0, lat[3]});
        rd(8'h16, v); chk("R6 srcB tap/wake/tilt", v, {5'b0, lat[2:0]});
        rd(8'h18, v); chk("R7 status bit", v, {3'b0, |lat, 4'b0});
        repeat (3) @(negedge clk);
        chk("R7 irq level", {7'b0, irq}, {7'b0, |lat});
        rd(8'h1A, v); chk("R8 release data", v, 8'h00);
        chk("R8 irq cleared", {7'b0, irq}, 8'h00);
        rd(8'h16, v); chk("R8 srcB cleared", v, 8'h00);
        rd(8'h15, v); chk("R8 srcA cleared", v, 8'h00);
      end
    end

    // R10 standby with all enables set
    wr(8'h1B, 8'h27);
    pulse(4'hF);
    chk("R10 irq standby", {7'b0, irq}, 8'h00);
    rd(8'h15, v); chk("R10 srcA standby", v, 8'h00);
    rd(8'h16, v); chk("R10 srcB standby", v, 8'h00);

    // R9 event in same cycle as release
    wr(8'h1B, 8'h87);
    pulse(4'b0010);
    @(negedge clk); rd_en = 1; addr = 8'h1A; ev_tilt = 0; ev_tap = 1;
    @(negedge clk); rd_en = 0; ev_tap = 0;
    chk("R9 irq kept", {7'b0, irq}, 8'h01);
    rd(8'h16, v); chk("R9 tap kept, wake cleared", v, 8'h04);

    // R11 unmapped reads and writes with a pending interrupt
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h15 || a == 8'h16 || a == 8'h18 || a == 8'h1B || a == 8'h1A) continue;
      rd(a[7:0], v); chk("R11 unmapped read", v, 8'h00);
      wr(a[7:0], 8'hFF);
    end
    rd(8'h1B, v); chk("R11 ctrl untouched", v, 8'h87);
    chk("R11 irq not cleared", {7'b0, irq}, 8'h01);
    rd(8'h16, v); chk("R11 srcB kept", v, 8'h04);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule